// File: doc/BRIEF.md
# Thermal Sensor Polling Sequencer

This block measures up to four on-chip temperature sensing points at regular intervals, using an analog-to-digital converter that lives elsewhere on the chip. It does no conversion itself. Instead it acts as a master on a simple memory-mapped bus and steps through a short script of bus transactions for each sensing point. First it writes the point's select value to an analog multiplexer. Next it writes a channel enable to the converter. It then reads a status/data word repeatedly, at a fixed spacing, until a programmable valid bit shows the expected level. The word is shifted right, and its low 12 bits are kept as that point's latest result.

All target addresses, write values, the valid-bit position and polarity, the shift, the poll spacing, the poll timeout and the round interval come from a flat configuration write port. One round visits the enabled points in ascending index order. The next round starts after a programmable wait. If polling gives up, a one-cycle interrupt pulse is raised, the point keeps its previous result, and the round moves on.

Top module: `thsq_top`

## Requirements
- R1: After reset the bus request, the interrupt and all four 12-bit results are 0, and no bus transaction is issued while the enable word (config offset 0, one bit per point) is 0.
- R2: Within a round, enabled points are visited in ascending index order and disabled points produce no transaction. For each point the sequence is: a write of the select value (offset 12+i) to the select address (offset 8); a write of the enable value (offset 10) to the enable address (offset 9); then reads from the read address (offset 11).
- R3: Write-control (offset 5) bit 0 gates the select write and bit 1 gates the enable write. A cleared bit removes that write from the sequence.
- R4: Between the acknowledge of the previous transaction and every read request, the bus request is low for exactly P+1 cycles, where P is the poll spacing at offset 3.
- R5: A read is valid when bit `pos` of the read data equals `pol`, where pos is bits 4:0 and pol is bit 5 of the valid-mask word at offset 6 (1 = active high).
- R6: On an acknowledged valid read, point i's result becomes bits 11:0 of the read data shifted right by the amount at offset 7, visible the cycle after the acknowledge. No other event changes a result.
- R7: With timeout limit L (offset 4), the (L+1)-th consecutive invalid read of a point raises the interrupt for exactly one cycle, the cycle after its acknowledge. The point's result is left unchanged, and the sequence proceeds to the next enabled point or ends the round.
- R8: Between the last read acknowledge of a round and the first request of the next, the request is low for exactly U*S*256+1 cycles, where U is offset 1 bits 9:0 and S is offset 2 bits 9:0. When both writes are disabled, P+1 more cycles are added. Offset 2 bits 25:16 have no effect.
- R9: Once raised, the request and its address, write flag and write data stay unchanged until acknowledged.
- R10: Clearing the enable word stops all bus activity from the next round on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration word offset |
| cfgWdata | input | 32 | Configuration write data |
| busReq | output | 1 | Bus transaction request |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | 32 | Transaction address |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | Transaction acknowledge |
| busRdata | input | 32 | Read data, valid with busAck |
| sensResult | output | 48 | Results, point i at bits 12i+11:12i |
| timeoutIrq | output | 1 | One-cycle poll-timeout pulse |

## Verification
The bench targets the skip rules, where a design that ignores an enable or write-control bit issues extra writes, or transactions for the wrong point, at the wrong addresses. It checks the exact idle spacing before each read and between rounds, including the extra poll gap when no write precedes the first read. An off-by-one counter moves every later request by a cycle. It exercises an active-low valid bit with a shifted result, where a wrong polarity or shift stores garbage or waits forever. It also drives a point past its timeout, where an early or late give-up shows up as a missing, doubled or misplaced interrupt pulse or as a result overwritten by invalid data.

// File: rtl/thsq_pkg.sv
package thsq_pkg;
  localparam int MAX_SENS = 4;
  localparam int IDX_W = 2;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = 32;

  localparam logic [CFG_AW-1:0] CFG_ENABLE   = 4'd0;
  localparam logic [CFG_AW-1:0] CFG_UNIT     = 4'd1;
  localparam logic [CFG_AW-1:0] CFG_INTERVAL = 4'd2;
  localparam logic [CFG_AW-1:0] CFG_POLL     = 4'd3;
  localparam logic [CFG_AW-1:0] CFG_TIMEOUT  = 4'd4;
  localparam logic [CFG_AW-1:0] CFG_WRCTRL   = 4'd5;
  localparam logic [CFG_AW-1:0] CFG_VMASK    = 4'd6;
  localparam logic [CFG_AW-1:0] CFG_SHIFT    = 4'd7;
  localparam logic [CFG_AW-1:0] CFG_SELADDR  = 4'd8;
  localparam logic [CFG_AW-1:0] CFG_ENADDR   = 4'd9;
  localparam logic [CFG_AW-1:0] CFG_ENVAL    = 4'd10;
  localparam logic [CFG_AW-1:0] CFG_RDADDR   = 4'd11;
  localparam logic [CFG_AW-1:0] CFG_SELVAL0  = 4'd12;

  typedef enum logic [2:0] {ST_WAIT, ST_SEL, ST_EN, ST_GAP, ST_READ} seqState_t;
  typedef enum logic [1:0] {PH_IDLE, PH_SEL, PH_EN, PH_READ} busPhase_t;

  typedef struct packed {
    busPhase_t             phase;
    logic [IDX_W-1:0]      idx;
    logic                  storeResult;
    logic                  raiseIrq;
  } seqStrobe_t;

  // Lowest enabled index at or above 'from'; MSB of the result flags a hit.
  function automatic logic [IDX_W:0] pickNext(input logic [MAX_SENS-1:0] en,
                                               input logic [IDX_W:0] from);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = MAX_SENS - 1; i >= 0; i--)
      if (en[i] && (i >= int'(from))) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction
endpackage

// File: rtl/thsq_ctrl.sv
module thsq_ctrl
  import thsq_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int POLL_W = 16,
  parameter int WAIT_W = 28
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MAX_SENS-1:0] sensEnable,
  input  logic [1:0]          wrCtrl,
  input  logic [POLL_W-1:0]   pollInt,
  input  logic [CNT_W-1:0]    timeoutLim,
  input  logic [WAIT_W-1:0]   waitTotal,
  input  logic                rdValid,
  input  logic                busAck,
  output logic                busReq,
  output seqStrobe_t          strobe
);
  seqState_t        state;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] badCnt;
  logic [IDX_W:0]   nextPick;
  seqState_t        entrySt;
  logic             readDone;
  logic             giveUp;

  always_comb begin
    nextPick = pickNext(sensEnable, (state == ST_WAIT) ? '0 : ((IDX_W+1)'(idx) + 1'b1));
    entrySt  = wrCtrl[0] ? ST_SEL : (wrCtrl[1] ? ST_EN : ST_GAP);
    readDone = (state == ST_READ) && busAck;
    giveUp   = !rdValid && (badCnt >= timeoutLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_WAIT;
      idx    <= '0;
      cnt    <= '0;
      badCnt <= '0;
      busReq <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (cnt == '0) begin
            if (nextPick[IDX_W]) begin
              idx    <= nextPick[IDX_W-1:0];
              state  <= entrySt;
              busReq <= (entrySt != ST_GAP);
              cnt    <= CNT_W'(pollInt);
              badCnt <= '0;
            end else begin
              cnt <= CNT_W'(waitTotal);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SEL: if (busAck) begin
          if (wrCtrl[1]) begin
            state <= ST_EN;
          end else begin
            state  <= ST_GAP;
            busReq <= 1'b0;
            cnt    <= CNT_W'(pollInt);
          end
        end
        ST_EN: if (busAck) begin
          state  <= ST_GAP;
          busReq <= 1'b0;
          cnt    <= CNT_W'(pollInt);
        end
        ST_GAP: begin
          if (cnt == '0) begin
            state  <= ST_READ;
            busReq <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_READ: if (busAck) begin
          busReq <= 1'b0;
          if (rdValid || giveUp) begin
            if (nextPick[IDX_W]) begin
              idx    <= nextPick[IDX_W-1:0];
              state  <= entrySt;
              busReq <= (entrySt != ST_GAP);
              cnt    <= CNT_W'(pollInt);
              badCnt <= '0;
            end else begin
              state <= ST_WAIT;
              cnt   <= CNT_W'(waitTotal);
            end
          end else begin
            badCnt <= badCnt + 1'b1;
            state  <= ST_GAP;
            cnt    <= CNT_W'(pollInt);
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_SEL:  strobe.phase = PH_SEL;
      ST_EN:   strobe.phase = PH_EN;
      ST_READ: strobe.phase = PH_READ;
      default: strobe.phase = PH_IDLE;
    endcase
    strobe.idx         = idx;
    strobe.storeResult = readDone && rdValid;
    strobe.raiseIrq    = readDone && giveUp;
  end

  // R2: within a round the visited index never moves backwards
  p_ascending_idx_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_WAIT) && $past(state != ST_WAIT) |-> idx >= $past(idx));
endmodule

// File: rtl/thsq_dpath.sv
module thsq_dpath
  import thsq_pkg::*;
#(
  parameter int NUM_SENS = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int RES_W    = 12,
  parameter int CNT_W    = 32,
  parameter int POLL_W   = 16,
  parameter int WAIT_W   = 28
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [CFG_AW-1:0]         cfgAddr,
  input  logic [CFG_DW-1:0]         cfgWdata,
  input  seqStrobe_t                strobe,
  input  logic [DATA_W-1:0]         busRdata,
  output logic [ADDR_W-1:0]         busAddr,
  output logic                      busWe,
  output logic [DATA_W-1:0]         busWdata,
  output logic                      rdValid,
  output logic [MAX_SENS-1:0]       sensEnable,
  output logic [1:0]                wrCtrl,
  output logic [POLL_W-1:0]         pollInt,
  output logic [CNT_W-1:0]          timeoutLim,
  output logic [WAIT_W-1:0]         waitTotal,
  output logic [NUM_SENS*RES_W-1:0] resFlat,
  output logic                      timeoutIrq
);
  localparam int SHIFT_W = $clog2(DATA_W);

  logic [NUM_SENS-1:0] enReg;
  logic [9:0]          unitReg, sensIntReg;
  logic [SHIFT_W-1:0]  posReg, shiftReg;
  logic                polReg;
  logic [ADDR_W-1:0]   selAddr, enAddr, rdAddr;
  logic [DATA_W-1:0]   enVal;
  logic [DATA_W-1:0]   selVal [NUM_SENS];
  logic [DATA_W-1:0]   shifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0; unitReg <= '0; sensIntReg <= '0; pollInt <= '0;
      timeoutLim <= '1; wrCtrl <= 2'b11; posReg <= '0; polReg <= 1'b0;
      shiftReg <= '0; selAddr <= '0; enAddr <= '0; enVal <= '0; rdAddr <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        CFG_ENABLE:   enReg      <= cfgWdata[NUM_SENS-1:0];
        CFG_UNIT:     unitReg    <= cfgWdata[9:0];
        CFG_INTERVAL: sensIntReg <= cfgWdata[9:0];
        CFG_POLL:     pollInt    <= cfgWdata[POLL_W-1:0];
        CFG_TIMEOUT:  timeoutLim <= CNT_W'(cfgWdata);
        CFG_WRCTRL:   wrCtrl     <= cfgWdata[1:0];
        CFG_VMASK:    begin posReg <= cfgWdata[SHIFT_W-1:0]; polReg <= cfgWdata[5]; end
        CFG_SHIFT:    shiftReg   <= cfgWdata[SHIFT_W-1:0];
        CFG_SELADDR:  selAddr    <= ADDR_W'(cfgWdata);
        CFG_ENADDR:   enAddr     <= ADDR_W'(cfgWdata);
        CFG_ENVAL:    enVal      <= DATA_W'(cfgWdata);
        CFG_RDADDR:   rdAddr     <= ADDR_W'(cfgWdata);
        default: ;
      endcase
    end
  end

  assign sensEnable = MAX_SENS'(enReg);
  assign waitTotal  = (WAIT_W'(unitReg) * WAIT_W'(sensIntReg)) << 8;
  assign rdValid    = (busRdata[posReg] == polReg);
  assign shifted    = busRdata >> shiftReg;

  always_comb begin
    busWe    = (strobe.phase != PH_READ);
    busAddr  = '0;
    busWdata = '0;
    case (strobe.phase)
      PH_SEL:  begin busAddr = selAddr; busWdata = selVal[strobe.idx]; end
      PH_EN:   begin busAddr = enAddr;  busWdata = enVal; end
      PH_READ: busAddr = rdAddr;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NUM_SENS; i++) begin : g_point
    always_ff @(posedge clk) begin
      if (!rstN) begin
        selVal[i] <= '0;
        resFlat[i*RES_W +: RES_W] <= '0;
      end else begin
        if (cfgWe && (cfgAddr == CFG_SELVAL0 + CFG_AW'(i)))
          selVal[i] <= DATA_W'(cfgWdata);
        if (strobe.storeResult && (strobe.idx == IDX_W'(i)))
          resFlat[i*RES_W +: RES_W] <= shifted[RES_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) timeoutIrq <= 1'b0;
    else       timeoutIrq <= strobe.raiseIrq;
  end

  // R6: results move only after an accepted valid read
  p_result_on_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resFlat) |-> $past(strobe.storeResult));
  // R7: the timeout interrupt is a single-cycle pulse
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |=> !timeoutIrq);
endmodule

// File: rtl/thsq_top.sv
module thsq_top
  import thsq_pkg::*;
#(
  parameter int NUM_SENS = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int RES_W    = 12,
  parameter int CNT_W    = 32,
  parameter int POLL_W   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [3:0]                cfgAddr,
  input  logic [31:0]               cfgWdata,
  output logic                      busReq,
  output logic                      busWe,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [DATA_W-1:0]         busWdata,
  input  logic                      busAck,
  input  logic [DATA_W-1:0]         busRdata,
  output logic [NUM_SENS*RES_W-1:0] sensResult,
  output logic                      timeoutIrq
);
  localparam int WAIT_W = 28;

  seqStrobe_t          strobe;
  logic                rdValid;
  logic [MAX_SENS-1:0] sensEnable;
  logic [1:0]          wrCtrl;
  logic [POLL_W-1:0]   pollInt;
  logic [CNT_W-1:0]    timeoutLim;
  logic [WAIT_W-1:0]   waitTotal;

  thsq_ctrl #(.CNT_W(CNT_W), .POLL_W(POLL_W), .WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sensEnable(sensEnable), .wrCtrl(wrCtrl),
    .pollInt(pollInt), .timeoutLim(timeoutLim), .waitTotal(waitTotal),
    .rdValid(rdValid), .busAck(busAck), .busReq(busReq), .strobe(strobe));

  thsq_dpath #(.NUM_SENS(NUM_SENS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W),
               .CNT_W(CNT_W), .POLL_W(POLL_W), .WAIT_W(WAIT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .strobe(strobe), .busRdata(busRdata), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .rdValid(rdValid), .sensEnable(sensEnable), .wrCtrl(wrCtrl),
    .pollInt(pollInt), .timeoutLim(timeoutLim), .waitTotal(waitTotal),
    .resFlat(sensResult), .timeoutIrq(timeoutIrq));

  // R9: an outstanding request holds its fields until acknowledged
  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata));
endmodule

// File: tb/thsq_top_tb.sv
module thsq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;
  logic [47:0] sensResult;
  logic        timeoutIrq;

  always #5 clk = ~clk;

  thsq_top u_dut (.clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata), .sensResult(sensResult), .timeoutIrq(timeoutIrq));

  typedef struct {
    logic        we;
    logic [31:0] addr, wdata, rdata;
    int          sens, tag;
    bit          store, irq, gapChk, roundChk;
  } txn_t;

  int checks = 0, errors = 0;
  txn_t q[$];
  txn_t cur;

  // reference configuration and plan
  int unsigned cfgEn = 0, cfgWr = 3, cfgPoll = 0, cfgPos = 0, cfgPol = 0, cfgShift = 0, cfgT = 0;
  logic [31:0] cfgTo = 32'hFFFF_FFFF;
  logic [31:0] selAddr = 32'h1000_0604, enAddr = 32'h2000_0008, enVal = 32'h0000_0800, rdAddr = 32'h2000_0040;
  logic [31:0] selVal [4] = '{32'h10, 32'h11, 32'h12, 32'h13};
  int          planBad [4] = '{0, 0, 0, 0};
  logic [31:0] planData [4] = '{32'h0000_0ABC, 32'h0000_0123, 32'h0000_0FED, 32'h0000_0456};
  int          wrTag = 2;
  int          resTag = 6;

  logic [11:0] expRes [4] = '{12'h0, 12'h0, 12'h0, 12'h0};
  bit          expIrq = 0, pendIrq = 0, pendStore = 0;
  int          pendSens = 0;
  logic [11:0] pendVal = '0;
  bit          gapValid = 0, txnOpen = 0;
  int          waitC = 0, lowCnt = 0, txnIdx = 0, roundsDone = 0, irqSeen = 0;
  logic [31:0] stAddr;

  function automatic string tagName(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";  5: return "R5";
      6: return "R6";  7: return "R7";  8: return "R8";  9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input int tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tagName(tag), act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic [31:0] d, input bit valid);
    logic [31:0] w;
    bit lvl;
    lvl = valid ? cfgPol[0] : !cfgPol[0];
    w = d;
    w[cfgPos] = lvl;
    return w;
  endfunction

  task automatic pushTxn(input logic we, input logic [31:0] a, input logic [31:0] wd, input logic [31:0] rd,
                         input int s, input int tag, input bit st, input bit ir, input bit gc, input bit rc);
    txn_t t;
    t.we = we; t.addr = a; t.wdata = wd; t.rdata = rd; t.sens = s; t.tag = tag;
    t.store = st; t.irq = ir; t.gapChk = gc; t.roundChk = rc;
    q.push_back(t);
  endtask

  // Expected transactions of one round, from the requirements (R2, R3, R5, R7)
  task automatic buildRound();
    bit first;
    first = 1;
    for (int i = 0; i < 4; i++) begin
      if (cfgEn[i]) begin
        if (cfgWr[0]) begin
          pushTxn(1, selAddr, selVal[i], 0, i, wrTag, 0, 0, 0, first && gapValid); first = 0;
        end
        if (cfgWr[1]) begin
          pushTxn(1, enAddr, enVal, 0, i, wrTag, 0, 0, 0, first && gapValid); first = 0;
        end
        if (longint'(planBad[i]) > longint'(cfgTo)) begin
          for (longint k = 0; k <= longint'(cfgTo); k++) begin
            pushTxn(0, rdAddr, 0, mkWord(~planData[i], 0), i, 2, 0, k == longint'(cfgTo), !first, first && gapValid);
            first = 0;
          end
        end else begin
          for (int k = 0; k < planBad[i]; k++) begin
            pushTxn(0, rdAddr, 0, mkWord(~planData[i], 0), i, 2, 0, 0, !first, first && gapValid);
            first = 0;
          end
          pushTxn(0, rdAddr, 0, mkWord(planData[i], 1), i, 2, 1, 0, !first, first && gapValid);
          first = 0;
        end
      end
    end
    gapValid = 1;
  endtask

  // Per-clock model and bus responder
  always @(negedge clk) begin
    if (!rstN) begin
      busAck = 0;
    end else begin
      if (pendStore) expRes[pendSens] = pendVal;
      expIrq = pendIrq;
      pendStore = 0; pendIrq = 0;
      for (int i = 0; i < 4; i++)
        chk(sensResult[i*12 +: 12] == expRes[i], resTag, 32'(sensResult[i*12 +: 12]), 32'(expRes[i]));
      chk(timeoutIrq == expIrq, 7, 32'(timeoutIrq), 32'(expIrq));
      if (timeoutIrq) irqSeen++;

      busAck = 0;
      if (busReq && !txnOpen) begin
        txnOpen = 1; waitC = 0; stAddr = busAddr;
        if (q.size() == 0) buildRound();
        if (q.size() == 0) begin
          chk(0, 10, busAddr, 0);
          cur.we = busWe; cur.addr = busAddr; cur.wdata = busWdata; cur.rdata = 0; cur.tag = 10;
          cur.store = 0; cur.irq = 0; cur.gapChk = 0; cur.roundChk = 0; cur.sens = 0;
        end else begin
          cur = q[0];
          if (cur.gapChk) chk(lowCnt == cfgPoll + 1, 4, lowCnt, cfgPoll + 1);
          if (cur.roundChk)
            chk(lowCnt == cfgT + 1 + ((cfgWr == 0) ? cfgPoll + 1 : 0), 8, lowCnt,
                cfgT + 1 + ((cfgWr == 0) ? cfgPoll + 1 : 0));
        end
        lowCnt = 0;
      end
      if (txnOpen) begin
        if (waitC >= txnIdx % 3) begin
          busAck = 1;
          busRdata = cur.rdata;
          chk(busAddr == stAddr, 9, busAddr, stAddr);
          chk(busWe == cur.we, cur.tag, 32'(busWe), 32'(cur.we));
          chk(busAddr == cur.addr, cur.tag, busAddr, cur.addr);
          if (cur.we) chk(busWdata == cur.wdata, cur.tag, busWdata, cur.wdata);
          if (cur.store) begin
            pendStore = 1; pendSens = cur.sens;
            pendVal = 12'((cur.rdata >> cfgShift) & 32'hFFF);
          end
          if (cur.irq) pendIrq = 1;
          if (q.size() != 0) begin
            void'(q.pop_front());
            if (q.size() == 0) roundsDone++;
          end
          txnOpen = 0; txnIdx++;
        end else begin
          waitC++;
        end
      end else if (!busReq) begin
        lowCnt++;
      end
    end
  end

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfgWe = 1; cfgAddr = a; cfgWdata = d;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic commonSetup();
    cfgWrite(4'd8, selAddr); cfgWrite(4'd9, enAddr); cfgWrite(4'd10, enVal); cfgWrite(4'd11, rdAddr);
    for (int i = 0; i < 4; i++) cfgWrite(4'(12 + i), selVal[i]);
  endtask

  task automatic applyCfg(input int en, input int wr, input int poll, input logic [31:0] tmo,
                          input int pos, input int pol, input int sh, input int unitV, input logic [31:0] intWord);
    cfgEn = 0; cfgWrite(4'd0, 0); gapValid = 0;
    cfgWr = wr; cfgPoll = poll; cfgTo = tmo; cfgPos = pos; cfgPol = pol; cfgShift = sh;
    cfgT = unitV * int'(intWord[9:0]) * 256;
    cfgWrite(4'd5, wr); cfgWrite(4'd3, poll); cfgWrite(4'd4, tmo);
    cfgWrite(4'd6, (pol << 5) | pos); cfgWrite(4'd7, sh); cfgWrite(4'd1, unitV); cfgWrite(4'd2, intWord);
    cfgEn = en; cfgWrite(4'd0, en);
  endtask

  task automatic runRounds(input int n);
    int target;
    target = roundsDone + n;
    wait (roundsDone >= target);
    cfgEn = 0; cfgWrite(4'd0, 0); gapValid = 0;
  endtask

  initial begin
    int startTxn, irqBase;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(busReq == 0, 1, 32'(busReq), 0);
    chk(timeoutIrq == 0, 1, 32'(timeoutIrq), 0);
    chk(sensResult == 0, 1, 32'(sensResult[31:0]), 0);
    rstN = 1;
    commonSetup();
    repeat (600) @(negedge clk);
    chk(txnIdx == 0, 1, txnIdx, 0);   // R1: enable 0 issues nothing

    // Scenario A: all writes, active-high valid at bit 12, points 0,1,3
    planBad = '{0, 2, 0, 0}; wrTag = 2; resTag = 6;
    applyCfg(4'b1011, 3, 2, 32'd3, 12, 1, 0, 1, 32'd1);
    runRounds(3);
    chk(sensResult[11:0] == 12'hABC, 6, 32'(sensResult[11:0]), 32'hABC);
    chk(sensResult[23:12] == 12'h123, 6, 32'(sensResult[23:12]), 32'h123);
    chk(sensResult[35:24] == 12'h000, 2, 32'(sensResult[35:24]), 0);   // R2: point 2 skipped

    // R10: disabled, no bus activity
    startTxn = txnIdx;
    repeat (700) @(negedge clk);
    chk(txnIdx == startTxn, 10, txnIdx, startTxn);

    // Scenario B: select write only, active-low valid at bit 3, shift 4, timeout on point 2
    planBad = '{0, 1, 5, 0}; planData[1] = 32'h0000_5670; wrTag = 3; resTag = 5;
    irqBase = irqSeen;
    applyCfg(4'b0110, 1, 1, 32'd2, 3, 0, 4, 1, 32'd1);
    runRounds(2);
    chk(irqSeen - irqBase == 2, 7, irqSeen - irqBase, 2);
    chk(sensResult[23:12] == 12'h567, 5, 32'(sensResult[23:12]), 32'h567);
    chk(sensResult[35:24] == 12'h000, 7, 32'(sensResult[35:24]), 0);

    // Scenario C: no writes, filter field nonzero, shift 8, valid bit 20
    planBad = '{0, 0, 0, 1}; planData[3] = 32'h000A_BC00; wrTag = 3; resTag = 6;
    applyCfg(4'b1000, 0, 3, 32'd4, 20, 1, 8, 1, 32'h0007_0001);
    runRounds(3);
    chk(sensResult[47:36] == 12'hABC, 6, 32'(sensResult[47:36]), 32'hABC);

    // Scenario D: enable write only, zero poll spacing, longer interval
    planBad = '{1, 0, 0, 0}; planData[0] = 32'h0000_1777; wrTag = 3; resTag = 6;
    applyCfg(4'b0001, 2, 0, 32'd1, 15, 1, 0, 2, 32'd1);
    runRounds(2);
    chk(sensResult[11:0] == 12'h777, 3, 32'(sensResult[11:0]), 32'h777);

    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule